// File: doc/BRIEF.md
# Multi-Source XOR Descriptor Engine

This block works through a ring of command descriptors held in a small word-addressed memory that lives inside the block. Each command either XORs two to eight source buffers into a destination buffer, or checks a parity buffer against its sources without writing anything. A third command type moves no data: it only leaves a completion record and can raise an interrupt. Every command leaves a completion record at an address that the command names.

Software fills the memory through a host write port. It then sets the head index to one past the last descriptor it has posted, and pulses start. The engine walks the ring from its own pointer until the pointer reaches the head index. An opcode it does not know, or a source count it cannot hold, stops the channel until reset. Writes from the engine are posted: they reach memory a fixed number of cycles after they are issued. A fence bit lets a command make sure that its results are in memory before the next command reads them.

Descriptor layout (eight words per ring entry, entry `i` at word `RING_BASE + 8*i`). Word 0 is the control word: bits [3:0] opcode (0 = null, 1 = XOR compute, 2 = XOR validate), bit 4 interrupt enable, bit 5 fence, bits [10:8] source count minus two, bits [21:16] transfer length in words minus one. Word 1 holds source 0, word 2 the destination, word 3 the completion address, and words 4 to 7 hold sources 1 to 4. Sources 5 to 7 sit in words 0 to 2 of the following ring entry.

Top module: `xor_desc_engine`

## Requirements
- R1: A source-count field value c selects c+2 sources. The value 7 is not accepted: the channel halts with `err_halt` set and processes nothing more.
- R2: Sources 0..4 come from words 1, 4, 5, 6, 7 of the base entry. When the field is above 3 (more than five sources), sources 5..7 come from words 0, 1, 2 of the next ring entry.
- R3: In compute mode (opcode 1), destination word w receives the XOR of word w of every source, for w = 0 up to the length field (bits [21:16], length minus one).
- R4: In validate mode (opcode 2), the destination is read as one more source and no data word is written. Completion bit 31 is set if any word of the XOR sum is non-zero, and clear otherwise.
- R5: A null descriptor (opcode 0) moves no data and writes its completion record. It gives a one-cycle `irq` pulse only when control bit 4 is set.
- R6: Each descriptor writes one completion record to the address in its word 3. The record holds bit 30 = 1, bit 31 = the validate failure flag, and the ring index of the base entry in the low bits.
- R7: Engine writes reach memory WR_LAT cycles after they are issued. With control bit 5 (fence) set, the next descriptor is not fetched until all earlier writes, its completion record included, have reached memory.
- R8: After a descriptor that uses an extension, the ring pointer moves on by two entries, otherwise by one. The pointer wraps modulo the ring size.
- R9: A start pulse while idle begins processing at the engine's pointer. Processing stops when the pointer equals `head_idx`. `idle` is high only when stopped with no write pending, and a start with the pointer equal to the head does nothing.
- R10: An opcode other than 0, 1 or 2 halts the channel. `err_halt` stays set, `idle` stays low and no further memory write is issued until reset.
- R11: After reset `idle` is 1, `irq` and `err_halt` are 0, and the ring pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin ring processing when idle |
| head_idx | input | IDX_W | Index one past the last posted descriptor |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | ADDR_W | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | ADDR_W | Host read word address |
| host_rdata | output | 32 | Memory word at host_raddr (combinational) |
| idle | output | 1 | Stopped with no posted write outstanding |
| irq | output | 1 | One-cycle interrupt from a null descriptor |
| err_halt | output | 1 | Channel halted on a bad descriptor |

## Verification
A wrong source-slot mapping or a wrong source count shows up as a wrong destination word, and the bench reads it back as soon as `idle` returns. A pointer that fails to skip an extension makes the engine decode source addresses as a control word. That shows at once as `err_halt` and as a missing completion record for the next descriptor. A broken fence lets the next command read a stale word that was filled in beforehand, so the chained result is wrong. A validate flag that is lost or stuck shows up as bit 31 of the completion record of that same command.

// File: rtl/xor_desc_engine.sv
module xor_desc_engine #(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 3,
  parameter int RING_BASE = 0,
  parameter int WR_LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [31:0]       host_rdata,
  output logic              idle,
  output logic              irq,
  output logic              err_halt
);
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int NSRC      = 8;
  localparam logic [3:0] OP_NULL = 4'd0, OP_XOR = 4'd1, OP_XVAL = 4'd2;

  typedef enum logic [2:0] {S_IDLE=3'd0, S_FETCH=3'd1, S_XFER=3'd2,
                            S_COMPL=3'd3, S_FENCE=3'd4, S_HALT=3'd5} state_t;

  logic [31:0]       mem [MEM_WORDS];
  state_t            state;
  logic [IDX_W-1:0]  ptr, cur_idx, ptr_next;
  logic [3:0]        op_q, sidx, n_last;
  logic [2:0]        cnt_q;
  logic              int_q, fence_q, ext_q, fail_q;
  logic [5:0]        w, last_w;
  logic [31:0]       acc, rd, x;
  logic [ADDR_W-1:0] src_a [NSRC];
  logic [ADDR_W-1:0] slot_loc [NSRC];
  logic [ADDR_W-1:0] dest_a, cmpl_a, b_addr, e_addr, rd_addr;
  logic              is_val, last_src;

  logic [WR_LAT-1:0] wp_v;
  logic [ADDR_W-1:0] wp_a [WR_LAT];
  logic [31:0]       wp_d [WR_LAT];
  logic              wr_v, pipe_busy;
  logic [ADDR_W-1:0] wr_a;
  logic [31:0]       wr_d;

  assign host_rdata = mem[host_raddr];
  assign pipe_busy  = |wp_v;
  assign idle       = (state == S_IDLE) && !pipe_busy;
  assign err_halt   = (state == S_HALT);

  assign b_addr   = ADDR_W'(RING_BASE) + ADDR_W'({ptr, 3'b000});
  assign e_addr   = ADDR_W'(RING_BASE) + ADDR_W'({ptr + IDX_W'(1), 3'b000});
  assign ptr_next = ptr + (ext_q ? IDX_W'(2) : IDX_W'(1));

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      slot_loc[s] = (s < 5) ? b_addr + ADDR_W'((s == 0) ? 1 : s + 3)
                            : e_addr + ADDR_W'(s - 5);
  end

  assign is_val   = (op_q == OP_XVAL);
  assign n_last   = {1'b0, cnt_q} + 4'd1 + {3'b000, is_val};
  assign last_src = (sidx == n_last);
  assign rd_addr  = ((is_val && last_src) ? dest_a : src_a[sidx[2:0]]) + ADDR_W'(w);
  assign rd       = mem[rd_addr];
  assign x        = acc ^ rd;

  always_comb begin
    wr_v = 1'b0;
    wr_a = dest_a + ADDR_W'(w);
    wr_d = x;
    if (state == S_XFER && last_src && !is_val) wr_v = 1'b1;
    if (state == S_COMPL) begin
      wr_v = 1'b1;
      wr_a = cmpl_a;
      wr_d = {fail_q, 1'b1, 30'(cur_idx)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wp_v <= '0;
    else        wp_v <= {wp_v[WR_LAT-2:0], wr_v};
  end

  always_ff @(posedge clk) begin
    wp_a[0] <= wr_a;
    wp_d[0] <= wr_d;
    for (int i = 1; i < WR_LAT; i++) begin
      wp_a[i] <= wp_a[i-1];
      wp_d[i] <= wp_d[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
    if (wp_v[WR_LAT-1]) mem[wp_a[WR_LAT-1]] <= wp_d[WR_LAT-1];
  end

  always_ff @(posedge clk) begin
    if (state == S_FETCH)
      for (int s = 0; s < NSRC; s++) src_a[s] <= mem[slot_loc[s]][ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  ptr <= '0;     cur_idx <= '0;  irq <= 1'b0;
      op_q <= '0;       cnt_q <= '0;   int_q <= 1'b0;  fence_q <= 1'b0;
      ext_q <= 1'b0;    fail_q <= 1'b0; w <= '0;      last_w <= '0;
      sidx <= '0;       acc <= '0;     dest_a <= '0;   cmpl_a <= '0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (start && ptr != head_idx) state <= S_FETCH;
        S_FETCH: begin
          cur_idx <= ptr;
          op_q    <= mem[b_addr][3:0];
          int_q   <= mem[b_addr][4];
          fence_q <= mem[b_addr][5];
          cnt_q   <= mem[b_addr][10:8];
          last_w  <= mem[b_addr][21:16];
          dest_a  <= mem[b_addr + ADDR_W'(2)][ADDR_W-1:0];
          cmpl_a  <= mem[b_addr + ADDR_W'(3)][ADDR_W-1:0];
          fail_q  <= 1'b0;
          w       <= '0;
          sidx    <= '0;
          acc     <= '0;
          ext_q   <= 1'b0;
          if (mem[b_addr][3:0] == OP_NULL)
            state <= S_COMPL;
          else if ((mem[b_addr][3:0] == OP_XOR || mem[b_addr][3:0] == OP_XVAL)
                   && mem[b_addr][10:8] != 3'd7) begin
            ext_q <= (mem[b_addr][10:8] > 3'd3);
            state <= S_XFER;
          end else
            state <= S_HALT;
        end
        S_XFER: begin
          if (last_src) begin
            acc  <= '0;
            sidx <= '0;
            if (is_val && x != '0) fail_q <= 1'b1;
            if (w == last_w) state <= S_COMPL;
            else             w <= w + 6'd1;
          end else begin
            acc  <= x;
            sidx <= sidx + 4'd1;
          end
        end
        S_COMPL: begin
          irq <= (op_q == OP_NULL) && int_q;
          ptr <= ptr_next;
          if (fence_q)                 state <= S_FENCE;
          else if (ptr_next == head_idx) state <= S_IDLE;
          else                         state <= S_FETCH;
        end
        S_FENCE: if (!pipe_busy) state <= (ptr == head_idx) ? S_IDLE : S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

module xor_desc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       irq,
  input logic       err_halt,
  input logic       idle,
  input logic       wr_v,
  input logic       pipe_busy,
  input logic       is_val,
  input logic [3:0] sidx
);
  localparam logic [2:0] C_FETCH = 3'd1, C_XFER = 3'd2, C_FENCE = 3'd4;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |=> err_halt); // R10
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |-> (!wr_v && !idle)); // R10
  AST_VAL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_XFER && is_val) |-> !wr_v); // R4
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_XFER) |-> (sidx <= 4'd8)); // R1
  AST_FENCE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_FETCH && $past(state) == C_FENCE) |-> !$past(pipe_busy)); // R7
endmodule

bind xor_desc_engine xor_desc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .irq(irq), .err_halt(err_halt),
  .idle(idle), .wr_v(wr_v), .pipe_busy(pipe_busy), .is_val(is_val), .sidx(sidx)
);

// File: tb/sim_xor_desc_engine.sv
module sim_xor_desc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 3;

  logic          clk = 0, rst_n = 0, start = 0, host_we = 0;
  logic [IW-1:0] head_idx = '0;
  logic [AW-1:0] host_addr = '0, host_raddr = '0;
  logic [31:0]   host_wdata = '0, host_rdata;
  logic          idle, irq, err_halt;

  logic [31:0] sh [256];
  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit done = 0;

  xor_desc_engine #(.ADDR_W(AW), .IDX_W(IW), .RING_BASE(0), .WR_LAT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .head_idx(head_idx),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .idle(idle), .irq(irq), .err_halt(err_halt));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (irq) irq_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
    sh[a] = d;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = AW'(a);
    #1 d = host_rdata;
  endtask

  function automatic logic [31:0] ctl(input int op, input bit ie, input bit fe, input int cnt, input int len);
    return {10'b0, 6'(len - 1), 5'b0, 3'(cnt), 2'b0, fe, ie, 4'(op)};
  endfunction

  function automatic int sb(input int s);
    return 64 + s * 8;
  endfunction

  task automatic desc(input int idx, input logic [31:0] c, input int s0, input int dst,
                      input int cpl, input int s1, input int s2, input int s3, input int s4);
    int b = idx * 8;
    wr(b, c); wr(b + 1, s0); wr(b + 2, dst); wr(b + 3, cpl);
    wr(b + 4, s1); wr(b + 5, s2); wr(b + 6, s3); wr(b + 7, s4);
  endtask

  task automatic run(input int h, input string tag);
    bit got = 0;
    @(negedge clk);
    head_idx = IW'(h); start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (idle) got = 1;
    end
    chk(got, tag, 32'(got), 32'd1);
  endtask

  function automatic logic [31:0] rec(input bit f, input int idx);
    return {f, 1'b1, 30'(idx)};
  endfunction

  task automatic t_reset;
    chk(idle == 1, "R11 idle after reset", 32'(idle), 1);
    chk(irq == 0 && err_halt == 0, "R11 irq/err after reset", {30'b0, irq, err_halt}, 0);
  endtask

  task automatic t_fill;
    for (int a = 64; a < 256; a++) wr(a, (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0000 ^ 32'(a << 3));
    for (int a = 200; a < 216; a++) wr(a, 0);
  endtask

  task automatic t_xor2;
    logic [31:0] v;
    desc(0, ctl(1, 0, 0, 0, 4), sb(0), 128, 200, sb(1), 0, 0, 0);
    run(1, "R9 run to head 1");
    for (int k = 0; k < 4; k++) begin
      rd(128 + k, v);
      chk(v == (sh[sb(0)+k] ^ sh[sb(1)+k]), "R3 two-source compute", v, sh[sb(0)+k] ^ sh[sb(1)+k]);
    end
    rd(132, v);
    chk(v == sh[132], "R3 word past length untouched", v, sh[132]);
    rd(200, v);
    chk(v == rec(0, 0), "R6 completion record desc 0", v, rec(0, 0));
  endtask

  task automatic t_xor8;
    logic [31:0] v, e;
    desc(1, ctl(1, 0, 0, 6, 2), sb(0), 136, 201, sb(1), sb(2), sb(3), sb(4));
    wr(16, sb(5)); wr(17, sb(6)); wr(18, sb(7));
    run(3, "R9 run to head 3");
    for (int k = 0; k < 2; k++) begin
      e = 0;
      for (int s = 0; s < 8; s++) e ^= sh[sb(s)+k];
      rd(136 + k, v);
      chk(v == e, "R2 eight sources with extension", v, e);
    end
  endtask

  task automatic t_null_val;
    logic [31:0] v, e;
    int i0 = irq_cnt;
    desc(3, ctl(0, 1, 0, 0, 1), 0, 0, 203, 0, 0, 0, 0);
    desc(4, ctl(2, 0, 0, 1, 4), sb(0), 176, 204, sb(1), sb(2), 0, 0);
    for (int k = 0; k < 4; k++) wr(176 + k, sh[sb(0)+k] ^ sh[sb(1)+k] ^ sh[sb(2)+k]);
    run(5, "R9 run to head 5");
    rd(203, v);
    chk(v == rec(0, 3), "R8 extension slot skipped, null completion", v, rec(0, 3));
    chk(irq_cnt == i0 + 1, "R5 null with interrupt enable", 32'(irq_cnt - i0), 1);
    rd(204, v);
    chk(v == rec(0, 4), "R4 validate match clear", v, rec(0, 4));
    e = sh[sb(0)+2] ^ sh[sb(1)+2] ^ sh[sb(2)+2];
    rd(178, v);
    chk(v == e, "R4 validate leaves destination", v, e);
  endtask

  task automatic t_wrap_fence;
    logic [31:0] v, e;
    int i0 = irq_cnt;
    desc(5, ctl(2, 0, 0, 1, 4), sb(0), 184, 205, sb(1), sb(2), 0, 0);
    for (int k = 0; k < 4; k++)
      wr(184 + k, sh[sb(0)+k] ^ sh[sb(1)+k] ^ sh[sb(2)+k] ^ ((k == 2) ? 32'h1 : 32'h0));
    wr(144, 32'hDEAD_BEEF);
    desc(6, ctl(1, 0, 1, 0, 1), sb(0), 144, 206, sb(1), 0, 0, 0);
    desc(7, ctl(1, 0, 0, 0, 1), 144, 152, 207, sb(2), 0, 0, 0);
    run(0, "R8 run wrapping to head 0");
    rd(205, v);
    chk(v == rec(1, 5), "R4 validate mismatch sets bit 31", v, rec(1, 5));
    e = sh[sb(0)] ^ sh[sb(1)] ^ sh[sb(2)];
    rd(152, v);
    chk(v == e, "R7 fenced result seen by next command", v, e);
    rd(207, v);
    chk(v == rec(0, 7), "R6 completion desc 7", v, rec(0, 7));
    chk(irq_cnt == i0, "R5 no interrupt from data commands", 32'(irq_cnt - i0), 0);
    desc(0, ctl(0, 0, 0, 0, 1), 0, 0, 208, 0, 0, 0, 0);
    run(1, "R8 wrapped pointer at entry 0");
    rd(208, v);
    chk(v == rec(0, 0), "R8 wrapped null completion", v, rec(0, 0));
    chk(irq_cnt == i0, "R5 null without interrupt enable", 32'(irq_cnt - i0), 0);
  endtask

  task automatic t_bad_op;
    logic [31:0] v;
    desc(1, ctl(15, 0, 0, 0, 1), sb(0), 160, 209, sb(1), 0, 0, 0);
    @(negedge clk); head_idx = 2; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(err_halt == 1 && idle == 0, "R10 unknown opcode halts", {30'b0, err_halt, idle}, 32'h2);
    rd(209, v);
    chk(v == 0, "R10 no completion after halt", v, 0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    chk(idle == 1 && err_halt == 0, "R11 reset clears halt", {30'b0, idle, err_halt}, 32'h2);
    @(negedge clk); head_idx = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (10) begin
      @(negedge clk);
      chk(idle == 1, "R9 start with pointer at head does nothing", 32'(idle), 1);
    end
    desc(0, ctl(1, 0, 0, 7, 1), sb(0), 168, 210, sb(1), sb(2), sb(3), sb(4));
    @(negedge clk); head_idx = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(err_halt == 1, "R1 count field 7 rejected", 32'(err_halt), 1);
    rd(168, v);
    chk(v == sh[168], "R1 no data written for rejected count", v, sh[168]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_xor2;
    t_xor8;
    t_null_val;
    t_wrap_fence;
    t_bad_op;
    t_restart;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule